// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the digital counter section of a synthesiser's loop. It takes the clock from a dual-modulus prescaler stage, which runs at VCO rate and is modelled here, and divides it by an 18-bit programmable ratio using the pulse-swallow method. A prescaler with a selectable base modulus P counts either P or P+1 input cycles. An 11-bit main counter and a 7-bit swallow counter choose the modulus for each prescaler cycle. The first A prescaler cycles of each divided period run at P+1 and the remaining N−A run at P. The total ratio is therefore N·P + A.

Each divided period ends with a single-cycle pulse on `div_pulse`, which is meant to feed a phase detector. A separate 15-bit counter divides the reference clock and produces `ref_pulse` in the same way. New ratios and prescaler selections are sampled during reset. After reset they are taken up only at the terminal count of the period in progress, so a reprogramming never produces a short or runt cycle.

Top module: `psw_synth_div`

## Requirements
- R1: While `rst` is high both `div_pulse` and `ref_pulse` are low, and the counters load the current divide word and selection. The first `div_pulse` appears after exactly N·P+A rising edges of `vco_clk` with `rst` low.
- R2: When A ≥ 1, consecutive `div_pulse` pulses are spaced N·P+A `vco_clk` cycles apart.
- R3: `pre_sel` sets the base modulus P: code 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64, and codes 4 to 7 all give 128. The prescaler divides by P or P+1.
- R4: `div_word[17:7]` is the main count N and `div_word[6:0]` is the swallow count A.
- R5: A = 0 gives a period of N·P, N = A gives N·(P+1), and N = 1, A = 0 gives P.
- R6: Every `div_pulse` is high for exactly one `vco_clk` cycle.
- R7: A change of `div_word` or `pre_sel` leaves the divided period in progress unchanged. The new values govern every period after the next terminal count.
- R8: `ref_pulse` repeats every R `ref_clk` cycles, where R = `ref_word` ≥ 1. The first pulse comes R edges after reset release, and R = 1 gives a pulse on every cycle.
- R9: A change of `ref_word` takes effect only after the reference period in progress has ended.
- R10: The word must satisfy N ≥ 1 and N ≥ A. The counters then hold N and A at full width (N up to 2047, A up to 127), and the swallow count is spent by the last prescaler cycle of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Prescaler-rate clock that is divided |
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| div_word | input | 18 | Main count N in [17:7], swallow count A in [6:0] |
| pre_sel | input | 3 | Prescaler base modulus select |
| ref_word | input | 15 | Reference division ratio R |
| div_pulse | output | 1 | One-cycle pulse per divided period (vco_clk domain) |
| ref_pulse | output | 1 | One-cycle pulse per reference period (ref_clk domain) |

## Verification
The in-line properties watch the following on every cycle:
- the divided pulse stays one cycle wide;
- the latched prescaler selection moves only at a terminal count;
- with a legal word, the main counter never reaches zero;
- the swallow count is used up by the final prescaler cycle;
- the reference count stays below its ratio.

Only the bench scenarios can show the actual period lengths. These cover every modulus code, the A = 0, N = A and full-width corners, and the exact latency after reset. The scenarios also show that a word changed mid-period leaves the remaining cycles of that period untouched, in both clock domains.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
  // Base modulus P for a select code: smallest modulus 2**pmin_log2,
  // doubling per code, codes at or beyond num_mod clamp to the largest.
  function automatic int unsigned base_mod(input int unsigned sel_i,
                                           input int unsigned pmin_log2,
                                           input int unsigned num_mod);
    int unsigned s;
    s = (sel_i >= num_mod) ? (num_mod - 1) : sel_i;
    return 32'd1 << (pmin_log2 + s);
  endfunction
endpackage

// File: rtl/psw_prescaler.sv
`timescale 1ns/1ps
module psw_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] len_m1,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  // Down counter; each run lasts len_m1+1 cycles (P or P+1).
  always_ff @(posedge clk) begin
    if (rst || cnt_q == '0) cnt_q <= len_m1;
    else                    cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/psw_swallow_ctl.sv
`timescale 1ns/1ps
module psw_swallow_ctl #(
  parameter int MAIN_W    = 11,
  parameter int SWAL_W    = 7,
  parameter int SEL_W     = 3,
  parameter int PMIN_LOG2 = 3,
  parameter int NUM_MOD   = 5,
  parameter int PRE_W     = PMIN_LOG2 + NUM_MOD,
  localparam int WORD_W   = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [WORD_W-1:0] div_word,
  input  logic [SEL_W-1:0]  pre_sel,
  output logic [PRE_W-1:0]  len_m1,
  output logic              term
);
  import psw_pkg::*;

  logic [MAIN_W-1:0] m_q;
  logic [SWAL_W-1:0] s_q, s_nxt;
  logic [SEL_W-1:0]  sel_q, sel_nxt;
  logic              legal_q;
  logic [MAIN_W-1:0] word_n;
  logic [SWAL_W-1:0] word_a;
  logic              word_ok;
  int unsigned       p_nxt;

  assign word_n  = div_word[WORD_W-1:SWAL_W];
  assign word_a  = div_word[SWAL_W-1:0];
  assign word_ok = (word_n != '0) && (word_n >= MAIN_W'(word_a));
  assign term    = tick && (m_q == MAIN_W'(1));

  // Next swallow count and selection decide the length of the prescaler
  // run that starts at this edge.
  always_comb begin
    if (rst || term) begin
      s_nxt   = word_a;
      sel_nxt = pre_sel;
    end else if (tick) begin
      s_nxt   = (s_q != '0) ? s_q - 1'b1 : '0;
      sel_nxt = sel_q;
    end else begin
      s_nxt   = s_q;
      sel_nxt = sel_q;
    end
    p_nxt  = base_mod(32'(sel_nxt), PMIN_LOG2, NUM_MOD);
    len_m1 = (s_nxt != '0) ? PRE_W'(p_nxt) : PRE_W'(p_nxt - 1);
  end

  always_ff @(posedge clk) begin
    s_q   <= s_nxt;
    sel_q <= sel_nxt;
    if (rst || term) begin
      m_q     <= word_n;
      legal_q <= word_ok;
    end else if (tick) begin
      m_q <= m_q - 1'b1;
    end
  end

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(sel_q));
  p_main_nonzero_r10: assert property (@(posedge clk) disable iff (rst || !legal_q)
    m_q != '0);
  p_swallow_drained_r10: assert property (@(posedge clk) disable iff (rst || !legal_q)
    term |-> (s_q <= SWAL_W'(1)));
endmodule

// File: rtl/psw_ref_div.sv
`timescale 1ns/1ps
module psw_ref_div #(
  parameter int REF_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] ref_word,
  output logic             ref_pulse
);
  logic [REF_W-1:0] rc_q, r_q;
  logic             rtick;

  assign rtick = (rc_q == '0);

  always_ff @(posedge clk) begin
    if (rst || rtick) begin
      rc_q <= ref_word - 1'b1;
      r_q  <= ref_word;
    end else begin
      rc_q <= rc_q - 1'b1;
    end
    ref_pulse <= !rst && rtick;
  end

  p_ref_range_r8: assert property (@(posedge clk) disable iff (rst || r_q == '0)
    rc_q < r_q);
endmodule

// File: rtl/psw_synth_div.sv
`timescale 1ns/1ps
module psw_synth_div #(
  parameter int MAIN_W    = 11,
  parameter int SWAL_W    = 7,
  parameter int SEL_W     = 3,
  parameter int REF_W     = 15,
  parameter int PMIN_LOG2 = 3,
  parameter int NUM_MOD   = 5,
  localparam int WORD_W   = MAIN_W + SWAL_W,
  localparam int PRE_W    = PMIN_LOG2 + NUM_MOD
) (
  input  logic              vco_clk,
  input  logic              ref_clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] div_word,
  input  logic [SEL_W-1:0]  pre_sel,
  input  logic [REF_W-1:0]  ref_word,
  output logic              div_pulse,
  output logic              ref_pulse
);
  logic [PRE_W-1:0] len_m1;
  logic             tick, term;

  psw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(vco_clk), .rst(rst), .len_m1(len_m1), .tick(tick)
  );

  psw_swallow_ctl #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .SEL_W(SEL_W),
    .PMIN_LOG2(PMIN_LOG2), .NUM_MOD(NUM_MOD), .PRE_W(PRE_W)
  ) u_ctl (
    .clk(vco_clk), .rst(rst), .tick(tick), .div_word(div_word),
    .pre_sel(pre_sel), .len_m1(len_m1), .term(term)
  );

  psw_ref_div #(.REF_W(REF_W)) u_ref (
    .clk(ref_clk), .rst(rst), .ref_word(ref_word), .ref_pulse(ref_pulse)
  );

  always_ff @(posedge vco_clk) div_pulse <= !rst && term;

  p_pulse_single_r6: assert property (@(posedge vco_clk) disable iff (rst)
    div_pulse |=> !div_pulse);
endmodule

// File: tb/sim_psw_synth_div.sv
`timescale 1ns/1ps
module sim_psw_synth_div;
  logic        vco_clk = 0, ref_clk = 0, rst = 1;
  logic [17:0] div_word;
  logic [2:0]  pre_sel;
  logic [14:0] ref_word;
  logic        div_pulse, ref_pulse;
  int total = 0, bad = 0, cyc = 0, c;

  psw_synth_div u0 (.vco_clk(vco_clk), .ref_clk(ref_clk), .rst(rst),
    .div_word(div_word), .pre_sel(pre_sel), .ref_word(ref_word),
    .div_pulse(div_pulse), .ref_pulse(ref_pulse));

  always #5 vco_clk = ~vco_clk;
  always #7 ref_clk = ~ref_clk;

  // N, A, select code, expected period (hand computed from N*P+A)
  localparam int NV = 14;
  localparam int TN[NV] = '{10, 5, 7, 1, 3, 2, 1, 4, 20, 100, 127, 2047, 3, 1};
  localparam int TA[NV] = '{3, 0, 7, 0, 2, 1, 1, 0, 5, 99, 127, 127, 0, 0};
  localparam int TS[NV] = '{0, 1, 0, 0, 2, 3, 4, 7, 1, 0, 0, 0, 5, 6};
  localparam int TE[NV] = '{83, 80, 63, 8, 98, 129, 129, 512, 325, 899, 1143, 16503, 384, 128};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_word(input int n, input int a, input int s);
    div_word = {11'(n), 7'(a)};  // R4: N in [17:7], A in [6:0]
    pre_sel  = 3'(s);
  endtask

  task automatic next_div(output int k);
    k = 0;
    do begin @(negedge vco_clk); k++; end while (!div_pulse);
  endtask

  task automatic next_ref(output int k);
    k = 0;
    do begin @(negedge ref_clk); k++; end while (!ref_pulse);
  endtask

  always @(posedge vco_clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    set_word(10, 3, 0);
    ref_word = 15'd300;
    repeat (4) @(negedge vco_clk);
    chk("R1 div low in reset", int'(div_pulse), 0);
    chk("R1 ref low in reset", int'(ref_pulse), 0);
    rst = 0;
    next_div(c);
    chk("R1 first div latency", c, 83);
    @(negedge vco_clk);
    chk("R6 pulse one cycle", int'(div_pulse), 0);

    // table walk: R2 R3 R5 R10
    for (int i = 0; i < NV; i++) begin
      set_word(TN[i], TA[i], TS[i]);
      next_div(c);                 // old period ends, new word latched
      next_div(c);
      chk($sformatf("R2/R3/R5/R10 vector %0d", i), c, TE[i]);
    end

    // R7: change mid-period, current period keeps old ratio
    set_word(5, 0, 1);
    next_div(c);
    next_div(c);
    chk("R7 setup period", c, 80);
    repeat (20) @(negedge vco_clk);
    set_word(7, 7, 0);
    next_div(c);
    chk("R7 remainder unchanged", c, 60);
    next_div(c);
    chk("R7 new ratio applied", c, 63);
    @(negedge vco_clk);
    chk("R6 pulse one cycle again", int'(div_pulse), 0);

    // reference divider, fresh reset: R8
    ref_word = 15'd6;
    @(negedge ref_clk);
    rst = 1;
    repeat (4) @(negedge ref_clk);
    chk("R8 ref low in reset", int'(ref_pulse), 0);
    rst = 0;
    next_ref(c);
    chk("R8 first ref latency", c, 6);
    next_ref(c);
    chk("R8 ref period 6", c, 6);
    ref_word = 15'd1;
    next_ref(c);
    next_ref(c);
    chk("R8 ref period 1", c, 1);
    next_ref(c);
    chk("R8 ref period 1 repeat", c, 1);

    // R9: mid-period change
    ref_word = 15'd4;
    next_ref(c);
    next_ref(c);
    chk("R9 setup period", c, 4);
    repeat (2) @(negedge ref_clk);
    ref_word = 15'd9;
    next_ref(c);
    chk("R9 remainder unchanged", c, 2);
    next_ref(c);
    chk("R9 new ratio applied", c, 9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule